// File: doc/BRIEF.md
# Logic-Locked Datapath with Scan Key Bypass

This block wraps a small fixed combinational function whose internal nets each pass through a two-input key gate. A key gate is either XOR or XNOR. The other input of the gate is one bit of a stored unlock key. The function produces its intended outputs only when every stored key bit matches its gate's polarity. Any wrong bit inverts the net it guards, and the outputs then depart from the intended function.

The key is written once through a single-cycle load strobe. A two-state controller moves from `KS_LOCKED` to `KS_ACTIVE` on that strobe (transition LOAD). It stays in `KS_ACTIVE` until reset (transition HOLD), and while it does, it ignores every further load.

A four-flop scan chain supports manufacturing test on a part that has not been unlocked. While scan enable is high, the chain shifts, and every key gate takes its second input from its own chain flop instead of from the key register. Structural patterns therefore need no knowledge of the key. The key register is never part of the chain, so it cannot be shifted out.

Top module: `lockdp_top`

## Requirements
- R1: After reset, `activated` is 0, the stored key is 4'b0000, every scan flop is 0, and `scan_out` is 0.
- R2: With the key 4'b1010 loaded and `scan_enable` low, `func_out` equals the reference function for all 256 input values. The nets are m0 = in[0]&in[1], m1 = in[2]|in[3], m2 = in[4]^in[5] and m3 = ~(in[6]&in[7]). The outputs are out[0] = (m0|m1)^m2 and out[1] = (m1&m3)|(m2&~in[0]).
- R3: Net mi is guarded by key gate i. Gates 0 and 2 are XOR gates, which pass the net when their key bit is 0. Gates 1 and 3 are XNOR gates, which pass the net when their key bit is 1. When key bit i is wrong, net mi is inverted. For each single-bit-wrong key, the outputs follow that inverted-net function and differ from the reference for at least one input.
- R4: While `activated` is low and `scan_enable` is low, `func_out` is computed from the stored key 4'b0000. Nets m1 and m3 are therefore inverted.
- R5: A high `key_load` in `KS_LOCKED` stores `key_data` and raises `activated` on the next clock edge. In `KS_ACTIVE`, `activated` stays high and further loads leave the stored key and `func_out` unchanged.
- R6: While `scan_enable` is high, the chain shifts one place per clock: `scan_in` enters flop 0, flop i moves to flop i+1, and `scan_out` is flop 3. While `scan_enable` is low, all flops hold their values.
- R7: While `scan_enable` is high, key gate i uses scan flop i in place of key bit i, whatever the stored key holds. With the chain holding 4'b1010, the outputs equal the reference function.
- R8: The stored key never appears on `scan_out`. After activation, `scan_out` shows only bits that were shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_load | input | 1 | One-cycle strobe that writes the unlock key |
| key_data | input | 4 | Key value written on a load |
| activated | output | 1 | High once a key has been written |
| scan_enable | input | 1 | Test mode: shift chain and bypass the key |
| scan_in | input | 1 | Serial input to scan flop 0 |
| scan_out | output | 1 | Serial output from scan flop 3 |
| func_in | input | 8 | Data inputs of the locked function |
| func_out | output | 2 | Outputs of the locked function |

## Verification
The bench compares the outputs against the reference network for all 256 inputs in each of the following cases:
- before activation;
- after the correct key is loaded;
- for every single-bit-wrong key.

A gate with the wrong polarity, or a wrong key bit that fails to invert its net, shows up as a mismatch in those sweeps. In test mode, the bench tracks the expected chain contents cycle by cycle. A bypass mux that still reads the stored key, or a chain with a reversed or off-by-one shift, makes either `func_out` or `scan_out` diverge from that model. A second load after activation must change nothing, and shifting after unlock must never expose key bits. A controller that accepts later loads, or a chain wired to the key register, is caught there.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int unsigned LK_NUM_IN  = 8;
    localparam int unsigned LK_NUM_OUT = 2;
    localparam int unsigned LK_NUM_KG  = 4;

    // Gate polarity: bit set means XNOR gate (passes on key bit 1)
    localparam logic [LK_NUM_KG-1:0] LK_GATE_XNOR = 4'b1010;

    typedef enum logic {
        KS_LOCKED = 1'b0,
        KS_ACTIVE = 1'b1
    } ks_state_e;

endpackage

// File: rtl/lock_key_store.sv
module lock_key_store
    import lock_pkg::*;
#(
    parameter int unsigned KW = LK_NUM_KG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [KW-1:0] data_i,
    output logic [KW-1:0] key_o,
    output logic          active_o
);

    ks_state_e     state_q;
    ks_state_e     state_d;
    logic [KW-1:0] key_q;
    logic          take_key;

    // Next-state logic: LOAD moves to active, HOLD keeps it
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_LOCKED: if (load_i) state_d = KS_ACTIVE;
            KS_ACTIVE: state_d = KS_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_LOCKED;
        else        state_q <= state_d;
    end

    assign take_key = (state_q == KS_LOCKED) && load_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        key_q <= '0;
        else if (take_key) key_q <= data_i;
    end

    // Output process
    always_comb begin
        active_o = (state_q == KS_ACTIVE);
        key_o    = key_q;
    end

    // R5
    seal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |=> active_o);

    // R5
    key_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |=> $stable(key_o));

    // R1
    unloaded_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o |-> (key_o == '0));

endmodule

// File: rtl/lock_scan_chain.sv
module lock_scan_chain #(
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             sin_i,
    output logic [DEPTH-1:0] bits_o,
    output logic             sout_o
);

    logic [DEPTH-1:0] q;

    genvar s;
    generate
        for (s = 0; s < DEPTH; s++) begin : g_stage
            logic nxt;
            if (s == 0) begin : g_head
                assign nxt = sin_i;
            end else begin : g_body
                assign nxt = q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       q[s] <= 1'b0;
                else if (shift_i) q[s] <= nxt;
            end
        end
    endgenerate

    assign bits_o = q;
    assign sout_o = q[DEPTH-1];

    // R6
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (bits_o[0] == $past(sin_i)));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(bits_o));

endmodule

// File: rtl/lock_keyed_net.sv
module lock_keyed_net
    import lock_pkg::*;
#(
    parameter int unsigned      NI  = LK_NUM_IN,
    parameter int unsigned      NO  = LK_NUM_OUT,
    parameter int unsigned      NK  = LK_NUM_KG,
    parameter logic [NK-1:0]    POL = LK_GATE_XNOR
) (
    input  logic [NI-1:0] a_i,
    input  logic [NK-1:0] key_i,
    input  logic [NK-1:0] tbit_i,
    input  logic          test_i,
    output logic [NO-1:0] y_o
);

    logic [NK-1:0] pre;
    logic [NK-1:0] post;

    // Internal nets ahead of the key gates
    assign pre[0] = a_i[0] & a_i[1];
    assign pre[1] = a_i[2] | a_i[3];
    assign pre[2] = a_i[4] ^ a_i[5];
    assign pre[3] = ~(a_i[6] & a_i[7]);

    genvar g;
    generate
        for (g = 0; g < NK; g++) begin : g_kgate
            logic sel;
            assign sel = test_i ? tbit_i[g] : key_i[g];
            if (POL[g]) begin : g_xnor
                assign post[g] = ~(pre[g] ^ sel);
            end else begin : g_xor
                assign post[g] = pre[g] ^ sel;
            end
        end
    endgenerate

    assign y_o[0] = (post[0] | post[1]) ^ post[2];
    assign y_o[1] = (post[1] & post[3]) | (post[2] & ~a_i[0]);

endmodule

// File: rtl/lockdp_top.sv
module lockdp_top
    import lock_pkg::*;
#(
    parameter int unsigned NI = LK_NUM_IN,
    parameter int unsigned NO = LK_NUM_OUT,
    parameter int unsigned NK = LK_NUM_KG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_load,
    input  logic [NK-1:0] key_data,
    output logic          activated,
    input  logic          scan_enable,
    input  logic          scan_in,
    output logic          scan_out,
    input  logic [NI-1:0] func_in,
    output logic [NO-1:0] func_out
);

    logic [NK-1:0] key_w;
    logic [NK-1:0] tbit_w;

    lock_key_store #(.KW(NK)) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (key_load),
        .data_i   (key_data),
        .key_o    (key_w),
        .active_o (activated)
    );

    lock_scan_chain #(.DEPTH(NK)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (scan_enable),
        .sin_i   (scan_in),
        .bits_o  (tbit_w),
        .sout_o  (scan_out)
    );

    lock_keyed_net #(.NI(NI), .NO(NO), .NK(NK)) u_net (
        .a_i    (func_in),
        .key_i  (key_w),
        .tbit_i (tbit_w),
        .test_i (scan_enable),
        .y_o    (func_out)
    );

    // R8
    chain_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_enable |=> (scan_out == $past(tbit_w[NK-2])));

endmodule

// File: tb/sim_lockdp_top.sv
`timescale 1ns/1ps
module sim_lockdp_top;

    localparam logic [3:0] POL = 4'b1010;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       key_load;
    logic [3:0] key_data;
    logic       activated;
    logic       scan_enable;
    logic       scan_in;
    logic       scan_out;
    logic [7:0] func_in;
    logic [1:0] func_out;

    int n_chk = 0;
    int n_err = 0;
    logic [3:0] tb_chain;

    always #10 clk = ~clk;

    lockdp_top u0 (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_data(key_data),
        .activated(activated), .scan_enable(scan_enable), .scan_in(scan_in),
        .scan_out(scan_out), .func_in(func_in), .func_out(func_out)
    );

    // Reference network with selected nets inverted
    function automatic logic [1:0] ref_f(input logic [7:0] a, input logic [3:0] flip);
        logic m0, m1, m2, m3;
        m0 = (a[0] & a[1]) ^ flip[0];
        m1 = (a[2] | a[3]) ^ flip[1];
        m2 = (a[4] ^ a[5]) ^ flip[2];
        m3 = ~(a[6] & a[7]) ^ flip[3];
        return {(m1 & m3) | (m2 & ~a[0]), (m0 | m1) ^ m2};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Apply inputs after a falling edge; sample mid-low-phase
    task automatic step(input logic [7:0] a, input logic se, input logic si,
                        input logic ld, input logic [3:0] kd);
        @(negedge clk);
        if (scan_enable) tb_chain = {tb_chain[2:0], scan_in};
        func_in = a; scan_enable = se; scan_in = si; key_load = ld; key_data = kd;
        #5;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; key_load = 0; key_data = 0; scan_enable = 0; scan_in = 0; func_in = 0;
        tb_chain = 4'b0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 activated", {7'b0, activated}, 8'h0);
        check("R1 scan_out", {7'b0, scan_out}, 8'h0);

        // R4 pre-activation: stored key zero
        for (int a = 0; a < 256; a++) begin
            step(a[7:0], 0, 0, 0, 0);
            check("R4 locked out", {6'b0, func_out}, {6'b0, ref_f(a[7:0], 4'b0000 ^ POL)});
        end

        // R7 load chain with 1010, then rotate while sweeping
        for (int k = 0; k < 4; k++) begin
            step(8'h00, 1, POL[3-k], 0, 0);
            check("R6 scan_out", {7'b0, scan_out}, {7'b0, tb_chain[3]});
        end
        for (int a = 0; a < 256; a++) begin
            step(a[7:0], 1, tb_chain[3], 0, 0);
            check("R7 test out", {6'b0, func_out}, {6'b0, ref_f(a[7:0], tb_chain ^ POL)});
            check("R6 scan_out", {7'b0, scan_out}, {7'b0, tb_chain[3]});
        end
        // R6 hold with scan_enable low (model does not shift)
        for (int k = 0; k < 6; k++) begin
            step(8'h00, 0, ~scan_in, 0, 0);
            check("R6 hold", {7'b0, scan_out}, {7'b0, tb_chain[3]});
        end

        // R5 load correct key
        step(8'h00, 0, 0, 1, POL);
        check("R5 before edge", {7'b0, activated}, 8'h0);
        step(8'h00, 0, 0, 0, 0);
        check("R5 after edge", {7'b0, activated}, 8'h1);

        // R2 correct key sweep
        for (int a = 0; a < 256; a++) begin
            step(a[7:0], 0, 0, 0, 0);
            check("R2 unlocked out", {6'b0, func_out}, {6'b0, ref_f(a[7:0], 4'b0000)});
        end

        // R5 second load ignored
        step(8'h00, 0, 0, 1, 4'b0101);
        for (int a = 0; a < 256; a += 7) begin
            step(a[7:0], 0, 0, 0, 0);
            check("R5 reload ignored", {6'b0, func_out}, {6'b0, ref_f(a[7:0], 4'b0000)});
            check("R5 stays active", {7'b0, activated}, 8'h1);
        end

        // R8 shift after unlock: only shifted-in bits appear
        for (int k = 0; k < 10; k++) begin
            step(8'hA5, 1, k[0], 0, 0);
            check("R8 no key leak", {7'b0, scan_out}, {7'b0, tb_chain[3]});
            check("R7 bypass after unlock", {6'b0, func_out}, {6'b0, ref_f(8'hA5, tb_chain ^ POL)});
        end

        // R3 each single-bit-wrong key
        for (int i = 0; i < 4; i++) begin
            int diff;
            logic [3:0] bad;
            bad = 4'b0001 << i;
            diff = 0;
            do_reset();
            step(8'h00, 0, 0, 1, POL ^ bad);
            for (int a = 0; a < 256; a++) begin
                step(a[7:0], 0, 0, 0, 0);
                check("R3 wrong-key out", {6'b0, func_out}, {6'b0, ref_f(a[7:0], bad)});
                if (func_out !== ref_f(a[7:0], 4'b0000)) diff++;
            end
            check("R3 mismatch exists", {7'b0, diff > 0}, 8'h1);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule